// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a small accumulator machine with four macroinstructions: load, add, store and branch-if-accumulator-zero. It does not count time steps. A 16-word control store holds one 20-bit microword per address. A 4-bit microaddress register selects the word that is active. The word read at that address is copied into a microinstruction register, and that register drives the 14 datapath strobes directly.

Each microword has 14 strobe bits and 6 sequencing bits. The sequencing bits are a 4-bit next-address field, a dispatch flag and an OR-with-zero flag. The dispatch flag makes the next microaddress come from a table indexed by the opcode. The OR-with-zero flag ORs the accumulator-zero input into bit 0 of the next-address field.

All four instructions share one fetch routine, followed by one dispatch cycle. Each instruction then runs its own routine, which ends with a jump back to address 0. A taken branch goes through one extra word, at address 1. That word loads the PC from the address field of the IR.

Top module: `useq_sequencer`

## Requirements
- R1: While `rst_n` is low, `csar` is 0 and all of `strobes` are 0. After reset is released, the first clock edge moves `csar` to 2 and sets `strobes` to word 0.
- R2: The strobes lag the microaddress by one clock. In the cycle after `csar` holds address A, `strobes` shows the control bits of word A. The bit positions are: 0 PC to bus, 1 MAR load, 2 memory read, 3 PC increment, 4 MDR to bus, 5 IR load, 6 IR address to bus, 7 ACC load, 8 ACC to bus, 9 ALU add, 10 TEMP to bus, 11 MDR load, 12 memory write, 13 PC load.
- R3: The fetch visits addresses 0, 2, 3 and 4. Word 0 asserts PC-to-bus and MAR load. Word 2 asserts read and PC increment. Word 3 asserts MDR-to-bus and IR load. Word 4 asserts no strobes.
- R4: At address 4 the next address comes from the opcode, with 2'b00 load giving 5, 2'b01 add giving 8, 2'b10 store giving 12 and 2'b11 brz giving 15.
- R5: The load routine is 5 (IR address to bus, MAR load), then 6 (read), then 7 (MDR to bus, ACC load), then 0.
- R6: The add routine is 8 (IR address to bus, MAR load), then 9 (read), then 10 (ACC to bus, ALU add), then 11 (TEMP to bus, ACC load), then 0.
- R7: The store routine is 12 (IR address to bus, MAR load), then 13 (ACC to bus, MDR load), then 14 (write), then 0.
- R8: At address 15 with `acceq0` low, the next address is 0 and word 15 asserts no strobes.
- R9: At address 15 with `acceq0` high, the next address is 1. Word 1 asserts IR address to bus and PC load, and then goes to 0.
- R10: In every cycle at most one bus-driving strobe is high (bits 0, 4, 6, 8, 10), and read and write are never both high.
- R11: `opcode` has no effect at any address other than 4, and `acceq0` has no effect at any address other than 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| opcode | input | 2 | Opcode field of the instruction register |
| acceq0 | input | 1 | High when the accumulator is zero |
| strobes | output | 14 | Datapath control strobes from the microinstruction register |
| csar | output | 4 | Current microaddress |

## Verification
Each of the four opcodes is run through a complete instruction, and the microaddress and strobes are compared in every cycle with a trace the bench builds from the step tables. This separates the dispatch targets and the routines from one another. The branch is run once with the accumulator nonzero and once with it zero, which tells the OR-with-zero path apart from a plain jump to 0. Throughout each run, the opcode and zero flag are held at the opposite of their meaningful values everywhere except the one address that samples them. A sequencer that samples either input at the wrong address therefore diverges from the expected trace. A reset in the middle of an add checks the return to the idle state and the first fetch strobes after the reset.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int ADDR_W = 4;
  localparam int CTRL_W = 14;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int WORD_W = CTRL_W + ADDR_W + 2;

  // strobe bit positions
  localparam int B_PC_DRV   = 0;
  localparam int B_MAR_LD   = 1;
  localparam int B_RD       = 2;
  localparam int B_PC_INC   = 3;
  localparam int B_MDR_DRV  = 4;
  localparam int B_IR_LD    = 5;
  localparam int B_IRA_DRV  = 6;
  localparam int B_ACC_LD   = 7;
  localparam int B_ACC_DRV  = 8;
  localparam int B_ALU_ADD  = 9;
  localparam int B_TMP_DRV  = 10;
  localparam int B_MDR_LD   = 11;
  localparam int B_WR       = 12;
  localparam int B_PC_LD    = 13;

  typedef logic [CTRL_W-1:0] ctrl_t;
  typedef logic [ADDR_W-1:0] uaddr_t;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_ADD   = 2'b01,
    OP_STORE = 2'b10,
    OP_BRZ   = 2'b11
  } opcode_e;

  typedef struct packed {
    logic   or_zero;
    logic   dispatch;
    uaddr_t next;
    ctrl_t  ctrl;
  } uword_t;

  function automatic ctrl_t bit_of(input int idx);
    return ctrl_t'(1) << idx;
  endfunction

  localparam uaddr_t A_FETCH = uaddr_t'(0);
  localparam uaddr_t A_TAKEN = uaddr_t'(1);
  localparam uaddr_t A_LOAD  = uaddr_t'(5);
  localparam uaddr_t A_ADD   = uaddr_t'(8);
  localparam uaddr_t A_STORE = uaddr_t'(12);
  localparam uaddr_t A_BRZ   = uaddr_t'(15);

  function automatic uaddr_t dispatch_target(input logic [1:0] op);
    uaddr_t t;
    case (opcode_e'(op))
      OP_LOAD:  t = A_LOAD;
      OP_ADD:   t = A_ADD;
      OP_STORE: t = A_STORE;
      default:  t = A_BRZ;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/useq_ctrl_store.sv
module useq_ctrl_store
  import useq_pkg::*;
#(
  parameter int AW    = ADDR_W,
  parameter int WORDS = 1 << AW
) (
  input  logic [AW-1:0] addr,
  output uword_t        word
);

  function automatic uword_t entry(input int unsigned a);
    uword_t w;
    w = '0;
    case (a)
      0:  begin w.ctrl = bit_of(B_PC_DRV) | bit_of(B_MAR_LD);   w.next = uaddr_t'(2);  end
      1:  begin w.ctrl = bit_of(B_IRA_DRV) | bit_of(B_PC_LD);   w.next = A_FETCH;      end
      2:  begin w.ctrl = bit_of(B_RD) | bit_of(B_PC_INC);       w.next = uaddr_t'(3);  end
      3:  begin w.ctrl = bit_of(B_MDR_DRV) | bit_of(B_IR_LD);   w.next = uaddr_t'(4);  end
      4:  begin w.dispatch = 1'b1;                              w.next = A_FETCH;      end
      5:  begin w.ctrl = bit_of(B_IRA_DRV) | bit_of(B_MAR_LD);  w.next = uaddr_t'(6);  end
      6:  begin w.ctrl = bit_of(B_RD);                          w.next = uaddr_t'(7);  end
      7:  begin w.ctrl = bit_of(B_MDR_DRV) | bit_of(B_ACC_LD);  w.next = A_FETCH;      end
      8:  begin w.ctrl = bit_of(B_IRA_DRV) | bit_of(B_MAR_LD);  w.next = uaddr_t'(9);  end
      9:  begin w.ctrl = bit_of(B_RD);                          w.next = uaddr_t'(10); end
      10: begin w.ctrl = bit_of(B_ACC_DRV) | bit_of(B_ALU_ADD); w.next = uaddr_t'(11); end
      11: begin w.ctrl = bit_of(B_TMP_DRV) | bit_of(B_ACC_LD);  w.next = A_FETCH;      end
      12: begin w.ctrl = bit_of(B_IRA_DRV) | bit_of(B_MAR_LD);  w.next = uaddr_t'(13); end
      13: begin w.ctrl = bit_of(B_ACC_DRV) | bit_of(B_MDR_LD);  w.next = uaddr_t'(14); end
      14: begin w.ctrl = bit_of(B_WR);                          w.next = A_FETCH;      end
      15: begin w.or_zero = 1'b1;                               w.next = A_FETCH;      end
      default: w = '0;
    endcase
    return w;
  endfunction

  uword_t rom [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_rom
    assign rom[g] = entry(g);
  end

  assign word = rom[addr];

endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
  import useq_pkg::*;
(
  input  uword_t     word,
  input  logic [1:0] opcode,
  input  logic       acceq0,
  output uaddr_t     next_addr
);

  always_comb begin
    if (word.dispatch) begin
      next_addr = dispatch_target(opcode);
    end else if (word.or_zero) begin
      next_addr = word.next | uaddr_t'(acceq0);
    end else begin
      next_addr = word.next;
    end
  end

endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
  import useq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        opcode,
  input  logic              acceq0,
  output logic [CTRL_W-1:0] strobes,
  output logic [ADDR_W-1:0] csar
);

  uword_t cur_word;
  uaddr_t nxt;
  ctrl_t  csir;

  useq_ctrl_store #(.AW(ADDR_W)) i_store (
    .addr (csar),
    .word (cur_word)
  );

  useq_next_addr i_next (
    .word      (cur_word),
    .opcode    (opcode),
    .acceq0    (acceq0),
    .next_addr (nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csar <= A_FETCH;
      csir <= '0;
    end else begin
      csar <= nxt;
      csir <= cur_word.ctrl;
    end
  end

  assign strobes = csir;

endmodule

// File: rtl/useq_checker.sv
module useq_checker
  import useq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        opcode,
  input logic              acceq0,
  input logic [CTRL_W-1:0] strobes,
  input logic [ADDR_W-1:0] csar
);

  logic [4:0] drivers;
  assign drivers = {strobes[B_PC_DRV], strobes[B_MDR_DRV], strobes[B_IRA_DRV],
                    strobes[B_ACC_DRV], strobes[B_TMP_DRV]};

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (csar == A_FETCH && strobes == '0));

  assert_fetch_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    csar == A_FETCH |=> strobes == (bit_of(B_PC_DRV) | bit_of(B_MAR_LD)));

  assert_fetch_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    csar == A_FETCH |=> csar == uaddr_t'(2));

  assert_dispatch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    csar == uaddr_t'(4) |=> csar == dispatch_target($past(opcode)));

  assert_brz_cond_R8: assert property (@(posedge clk) disable iff (!rst_n)
    csar == A_BRZ |=> csar == uaddr_t'($past(acceq0)));

  assert_taken_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
    csar == A_TAKEN |=> (strobes == (bit_of(B_IRA_DRV) | bit_of(B_PC_LD)) && csar == A_FETCH));

  assert_one_driver_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(drivers) && !(strobes[B_RD] && strobes[B_WR]));

endmodule

bind useq_sequencer useq_checker i_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .opcode  (opcode),
  .acceq0  (acceq0),
  .strobes (strobes),
  .csar    (csar)
);

// File: tb/test_useq_sequencer.sv
module test_useq_sequencer;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  opcode = 2'b00;
  logic        acceq0 = 1'b0;
  logic [13:0] strobes;
  logic [3:0]  csar;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  useq_sequencer i_useq_sequencer (
    .clk     (clk),
    .rst_n   (rst_n),
    .opcode  (opcode),
    .acceq0  (acceq0),
    .strobes (strobes),
    .csar    (csar)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // expected next microaddress from R3..R9
  function automatic logic [3:0] exp_next(input logic [3:0] a, input logic [1:0] op, input logic z);
    case (a)
      4'd0: return 4'd2;
      4'd1: return 4'd0;
      4'd2: return 4'd3;
      4'd3: return 4'd4;
      4'd4: case (op)
              2'b00: return 4'd5;
              2'b01: return 4'd8;
              2'b10: return 4'd12;
              default: return 4'd15;
            endcase
      4'd5: return 4'd6;
      4'd6: return 4'd7;
      4'd8: return 4'd9;
      4'd9: return 4'd10;
      4'd10: return 4'd11;
      4'd12: return 4'd13;
      4'd13: return 4'd14;
      4'd15: return {3'b000, z};
      default: return 4'd0;
    endcase
  endfunction

  // expected strobes for a word, bit positions from R2
  function automatic logic [13:0] exp_word(input logic [3:0] a);
    case (a)
      4'd0:  return 14'h0003;                    // bits 0,1
      4'd1:  return 14'h2040;                    // bits 6,13
      4'd2:  return 14'h000C;                    // bits 2,3
      4'd3:  return 14'h0030;                    // bits 4,5
      4'd5, 4'd8, 4'd12: return 14'h0042;        // bits 1,6
      4'd6, 4'd9: return 14'h0004;               // bit 2
      4'd7:  return 14'h0090;                    // bits 4,7
      4'd10: return 14'h0300;                    // bits 8,9
      4'd11: return 14'h0480;                    // bits 7,10
      4'd13: return 14'h0900;                    // bits 8,11
      4'd14: return 14'h1000;                    // bit 12
      default: return 14'h0000;                  // words 4 and 15
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] a, input logic z);
    case (a)
      4'd0, 4'd2, 4'd3: return "R3";
      4'd4: return "R4 R11";
      4'd5, 4'd6, 4'd7: return "R5";
      4'd8, 4'd9, 4'd10, 4'd11: return "R6";
      4'd12, 4'd13, 4'd14: return "R7";
      4'd15: return z ? "R9 R11" : "R8 R11";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_exclusive();
    logic [4:0] drv;
    drv = {strobes[0], strobes[4], strobes[6], strobes[8], strobes[10]};
    chk("R10 drivers", 32'($countones(drv) <= 1), 32'd1);
    chk("R10 rd/wr", 32'(strobes[2] & strobes[12]), 32'd0);
  endtask

  // runs one instruction from address 0 back to address 0
  task automatic run_instr(input logic [1:0] op, input logic z);
    logic [3:0] cur;
    logic [3:0] nxt;
    cur = 4'd0;
    chk("R3 start", 32'(csar), 32'd0);
    for (int s = 0; s < 12; s++) begin
      opcode = (cur == 4'd4) ? op : ~op;      // R11: wrong value elsewhere
      acceq0 = (cur == 4'd15) ? z : ~z;
      nxt = exp_next(cur, op, z);
      @(negedge clk);
      chk({tag_of(cur, z), " csar"}, 32'(csar), 32'(nxt));
      chk({tag_of(cur, z), " R2 strobes"}, 32'(strobes), 32'(exp_word(cur)));
      chk_exclusive();
      cur = nxt;
      if (cur == 4'd0) break;
    end
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R1 csar in reset", 32'(csar), 32'd0);
    chk("R1 strobes in reset", 32'(strobes), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 first csar", 32'(csar), 32'd2);
    chk("R1 first strobes", 32'(strobes), 32'(exp_word(4'd0)));
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic test_mid_reset();
    opcode = 2'b01;
    repeat (6) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid reset csar", 32'(csar), 32'd0);
    chk("R1 mid reset strobes", 32'(strobes), 32'd0);
    rst_n = 1'b1;
  endtask

  initial begin
    test_reset();
    run_instr(2'b00, 1'b0);   // load
    run_instr(2'b01, 1'b1);   // add
    run_instr(2'b10, 1'b0);   // store
    run_instr(2'b11, 1'b0);   // brz not taken
    run_instr(2'b11, 1'b1);   // brz taken
    run_instr(2'b01, 1'b0);   // add again after taken branch
    test_mid_reset();
    run_instr(2'b00, 1'b1);   // load after mid reset
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule